// File: doc/BRIEF.md
# Cartridge Controller Register Gate

This block is the bus-facing register front end of a cartridge controller that hangs off an 8-bit CPU bus. Writes to the lower address regions control the controller itself. A write to region 0 or to region 2 sets or clears one of two unlock bits, and a write to region 1 picks the ROM bank. The register window occupies one further region. It can be read or written only while both unlock bits are set. Inside it, address bits 7:4 select one of sixteen register slots.

The window gives access to two tilt-sensor axes. Each axis is read as a low byte and a high byte. Two writes in sequence, a masked 0x55 followed by a masked 0xAA, fire a one-cycle request that asks the external sensor for a new sample. The sensor returns raw samples with a valid strobe. The block turns each raw sample into a 16-bit reading and holds it until the next valid strobe. One window slot is passed through to the pins of a serial EEPROM: a write there appears on a separate write port, and a read returns the pin byte from that port.

Top module: `cart_reg_gate`

## Requirements
- R1: A write to region 0 (bus_addr[15:13] = 0) with data 0x0A sets unlock bit 0 and leaves unlock bit 1 as it was. A write to region 0 with any other data clears both unlock bits.
- R2: A write to region 2 (bus_addr[15:13] = 2) with data 0x40 sets unlock bit 1. A write to region 2 with any other data clears only unlock bit 1.
- R3: A write to region 1 (bus_addr[15:13] = 1) loads rom_bank from bus_wdata[6:0] on the next clock edge.
- R4: The window is region 5 (bus_addr[15:13] = 5). While the two unlock bits are not both set, rd_data reads 0xFF for every window address, and window writes have no effect: no ee_wr pulse and no change to the handshake state.
- R5: An unlocked write to window slot 0x0 (bus_addr[7:4] = 0) arms the handshake when data & 0x55 == 0x55 and disarms it otherwise. An unlocked write to slot 0x1 fires sample_req for exactly one cycle, one cycle after the write, when the handshake is armed and data & 0xAA == 0xAA. Every slot-0x1 write disarms the handshake.
- R6: When smp_valid is high, the reading for each axis becomes ((-raw) >>> 21) + 0x81D0, taken to 16 bits. The negation and the arithmetic shift are done on 32 signed bits.
- R7: With sens_present = 1, slot 0x2 reads the low byte of X, slot 0x3 the high byte of X, slot 0x4 the low byte of Y and slot 0x5 the high byte of Y. With sens_present = 0, slots 0x2 and 0x4 read 0xFF and slots 0x3 and 0x5 read 0x07.
- R8: When unlocked, slot 0x6 reads 0x00 and slot 0x8 reads ee_pins. Every other slot reads 0xFF. An address outside region 5 also reads 0xFF.
- R9: An unlocked write to slot 0x8 raises ee_wr in the same cycle, with ee_wdata equal to bus_wdata. Writes to slots other than 0x0, 0x1 and 0x8 change no output and no state.
- R10: After reset, both unlock bits are clear, rom_bank is 0, the handshake is disarmed, sample_req is low, and both axis readings are 0x81D0.
- R11: An axis reading holds its value while smp_valid is low, even when the raw sample inputs change. A read in the same cycle as a capture returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| rd_data | output | 8 | Combinational read data for bus_addr |
| rom_bank | output | 7 | Selected ROM bank |
| sample_req | output | 1 | One-cycle request for a new sensor sample |
| sens_present | input | 1 | A sensor is fitted |
| smp_valid | input | 1 | Raw samples on smp_x and smp_y are valid |
| smp_x | input | 32 | Raw X sample, signed |
| smp_y | input | 32 | Raw Y sample, signed |
| ee_wr | output | 1 | Pin-byte write strobe to the serial EEPROM |
| ee_wdata | output | 8 | Pin byte written to the serial EEPROM |
| ee_pins | input | 8 | Pin byte read back from the serial EEPROM |

## Verification
A capture from the sensor and a bus read of the same axis byte can fall in the same cycle. The bench holds the read address on the X low byte, raises smp_valid with a new raw sample, and samples rd_data once before and once after that clock edge. The value read before the edge must be the old reading and the value read after it the new one. The bench also puts a locked write to slot 0x1 between the two halves of the handshake, then unlocks again. The handshake must still be armed, which shows that the locked write left it alone.

// File: rtl/cart_gate_pkg.sv
package cart_gate_pkg;
   localparam int unsigned DATA_W = 8;
   localparam int unsigned ADDR_W = 16;
   localparam int unsigned VAL_W  = 16;

   typedef enum logic [2:0] {
      RGN_UNLOCK0 = 3'd0,
      RGN_BANK    = 3'd1,
      RGN_UNLOCK1 = 3'd2
   } region_e;

   typedef enum logic [3:0] {
      SLOT_ARM   = 4'h0,
      SLOT_FIRE  = 4'h1,
      SLOT_X_LO  = 4'h2,
      SLOT_X_HI  = 4'h3,
      SLOT_Y_LO  = 4'h4,
      SLOT_Y_HI  = 4'h5,
      SLOT_ZERO  = 4'h6,
      SLOT_PINS  = 4'h8
   } slot_e;

   localparam logic [DATA_W-1:0] KEY_LO    = 8'h0A;
   localparam logic [DATA_W-1:0] KEY_HI    = 8'h40;
   localparam logic [DATA_W-1:0] ARM_MASK  = 8'h55;
   localparam logic [DATA_W-1:0] FIRE_MASK = 8'hAA;
   localparam logic [DATA_W-1:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/cart_unlock_ctl.sv
module cart_unlock_ctl
   import cart_gate_pkg::*;
#(
   parameter int unsigned BANK_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [2:0]        region,
   input  logic [DATA_W-1:0] wdata,
   output logic [1:0]        unlock,
   output logic [BANK_W-1:0] bank
);
   initial assert (BANK_W >= 1 && BANK_W <= DATA_W)
      else $error("BANK_W must fit in a bus byte");

   logic unused_hi;
   assign unused_hi = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unlock <= 2'b00;
         bank   <= '0;
      end else if (wr) begin
         unique case (region)
            RGN_UNLOCK0: unlock <= (wdata == KEY_LO) ? {unlock[1], 1'b1} : 2'b00;
            RGN_UNLOCK1: unlock[1] <= (wdata == KEY_HI);
            RGN_BANK:    bank <= wdata[BANK_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cart_latch_hs.sv
module cart_latch_hs
   import cart_gate_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_wr,
   input  logic              fire_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              sample_req
);
   logic armed_q;
   logic arm_hit, fire_hit;

   assign arm_hit  = (wdata & ARM_MASK)  == ARM_MASK;
   assign fire_hit = (wdata & FIRE_MASK) == FIRE_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         sample_req <= 1'b0;
      end else begin
         sample_req <= fire_wr && armed_q && fire_hit;
         if (arm_wr)       armed_q <= arm_hit;
         else if (fire_wr) armed_q <= 1'b0;
      end
   end
endmodule

// File: rtl/cart_tilt_axis.sv
module cart_tilt_axis
   import cart_gate_pkg::*;
#(
   parameter int unsigned     RAW_W  = 32,
   parameter int unsigned     SHIFT  = 21,
   parameter logic [VAL_W-1:0] OFFSET = 16'h81D0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [RAW_W-1:0] raw,
   output logic [VAL_W-1:0] value
);
   initial assert (SHIFT < RAW_W && RAW_W >= VAL_W)
      else $error("tilt axis widths inconsistent");

   logic signed [RAW_W-1:0] neg_w, shr_w;
   logic [RAW_W-1:0]        sum_w;
   logic                    unused_sum;

   assign neg_w = -$signed(raw);
   assign shr_w = neg_w >>> SHIFT;
   assign sum_w = $unsigned(shr_w) + RAW_W'(OFFSET);
   assign unused_sum = ^sum_w;

   always_ff @(posedge clk) begin
      if (!rst_n)    value <= OFFSET;
      else if (load) value <= sum_w[VAL_W-1:0];
   end
endmodule

// File: rtl/cart_reg_gate.sv
module cart_reg_gate
   import cart_gate_pkg::*;
#(
   parameter int unsigned      BANK_W     = 7,
   parameter int unsigned      RAW_W      = 32,
   parameter int unsigned      SHIFT      = 21,
   parameter logic [VAL_W-1:0] OFFSET     = 16'h81D0,
   parameter logic [2:0]       WIN_REGION = 3'd5,
   parameter logic [DATA_W-1:0] ABSENT_LO = 8'hFF,
   parameter logic [DATA_W-1:0] ABSENT_HI = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic [BANK_W-1:0] rom_bank,
   output logic              sample_req,
   input  logic              sens_present,
   input  logic              smp_valid,
   input  logic [RAW_W-1:0]  smp_x,
   input  logic [RAW_W-1:0]  smp_y,
   output logic              ee_wr,
   output logic [DATA_W-1:0] ee_wdata,
   input  logic [DATA_W-1:0] ee_pins
);
   localparam int unsigned AXES = 2;

   initial assert (WIN_REGION > 3'd2)
      else $error("window region overlaps a control region");

   logic [2:0]             region;
   logic [3:0]             slot;
   logic                   in_win, open, win_wr;
   logic [1:0]             unlock_w;
   logic [RAW_W-1:0]       raw_a [AXES];
   logic [VAL_W-1:0]       val_a [AXES];
   logic [DATA_W-1:0]      slot_byte;
   logic                   unused_addr;

   assign region      = bus_addr[15:13];
   assign slot        = bus_addr[7:4];
   assign unused_addr = ^{bus_addr[12:8], bus_addr[3:0]};
   assign in_win      = (region == WIN_REGION);
   assign open        = (unlock_w == 2'b11);
   assign win_wr      = bus_wr && in_win && open;

   cart_unlock_ctl #(.BANK_W(BANK_W)) u_unlock (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr),
      .region (region),
      .wdata  (bus_wdata),
      .unlock (unlock_w),
      .bank   (rom_bank)
   );

   cart_latch_hs u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_wr     (win_wr && slot == SLOT_ARM),
      .fire_wr    (win_wr && slot == SLOT_FIRE),
      .wdata      (bus_wdata),
      .sample_req (sample_req)
   );

   assign raw_a[0] = smp_x;
   assign raw_a[1] = smp_y;

   for (genvar g = 0; g < AXES; g++) begin : g_axis
      cart_tilt_axis #(
         .RAW_W  (RAW_W),
         .SHIFT  (SHIFT),
         .OFFSET (OFFSET)
      ) u_axis (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (smp_valid),
         .raw   (raw_a[g]),
         .value (val_a[g])
      );
   end

   assign ee_wr    = win_wr && (slot == SLOT_PINS);
   assign ee_wdata = bus_wdata;

   always_comb begin
      unique case (slot)
         SLOT_X_LO: slot_byte = sens_present ? val_a[0][7:0]  : ABSENT_LO;
         SLOT_X_HI: slot_byte = sens_present ? val_a[0][15:8] : ABSENT_HI;
         SLOT_Y_LO: slot_byte = sens_present ? val_a[1][7:0]  : ABSENT_LO;
         SLOT_Y_HI: slot_byte = sens_present ? val_a[1][15:8] : ABSENT_HI;
         SLOT_ZERO: slot_byte = '0;
         SLOT_PINS: slot_byte = ee_pins;
         default:   slot_byte = IDLE_BYTE;
      endcase
   end

   assign rd_data = (in_win && open) ? slot_byte : IDLE_BYTE;
endmodule

// File: rtl/cart_reg_gate_chk.sv
module cart_reg_gate_chk #(
   parameter int unsigned BANK_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [15:0]       bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        rd_data,
   input logic [BANK_W-1:0] rom_bank,
   input logic              sample_req,
   input logic              ee_wr,
   input logic [1:0]        unlock
);
   a_r1_unlock_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[15:13] == 3'd0 && bus_wdata != 8'h0A) |=> (unlock == 2'b00));

   a_r2_unlock_set: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[15:13] == 3'd2 && bus_wdata == 8'h40) |=> unlock[1]);

   a_r3_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[15:13] == 3'd1) |=> (rom_bank == $past(bus_wdata[BANK_W-1:0])));

   a_r4_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
      (unlock != 2'b11) |-> (rd_data == 8'hFF));

   a_r4_locked_no_pin_write: assert property (@(posedge clk) disable iff (!rst_n)
      (unlock != 2'b11) |-> !ee_wr);

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      sample_req |=> !sample_req);

   a_r5_fire_cause: assert property (@(posedge clk) disable iff (!rst_n)
      sample_req |-> $past(bus_wr && bus_addr[7:4] == 4'h1 && unlock == 2'b11));
endmodule

bind cart_reg_gate cart_reg_gate_chk #(.BANK_W(BANK_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .rd_data    (rd_data),
   .rom_bank   (rom_bank),
   .sample_req (sample_req),
   .ee_wr      (ee_wr),
   .unlock     (unlock_w)
);

// File: tb/cart_reg_gate_bench.sv
module cart_reg_gate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  rd_data;
   logic [6:0]  rom_bank;
   logic        sample_req;
   logic        sens_present = 1'b1;
   logic        smp_valid = 1'b0;
   logic [31:0] smp_x = 32'h0, smp_y = 32'h0;
   logic        ee_wr;
   logic [7:0]  ee_wdata;
   logic [7:0]  ee_pins = 8'h00;

   int n_checks = 0;
   int n_fail = 0;
   int req_cnt = 0;
   int ee_cnt = 0;
   logic [7:0] ee_last = 8'h00;

   localparam logic [15:0] WIN = 16'hA000;

   always #10 clk = ~clk;

   cart_reg_gate u_cart_reg_gate (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rd_data(rd_data), .rom_bank(rom_bank),
      .sample_req(sample_req), .sens_present(sens_present),
      .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y),
      .ee_wr(ee_wr), .ee_wdata(ee_wdata), .ee_pins(ee_pins)
   );

   always @(posedge clk) begin
      if (sample_req) req_cnt <= req_cnt + 1;
      if (ee_wr) begin
         ee_cnt  <= ee_cnt + 1;
         ee_last <= ee_wdata;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] conv(input logic [31:0] raw);
      logic signed [31:0] n;
      n = -$signed(raw);
      n = n >>> 21;
      n = n + 32'sh81D0;
      return n[15:0];
   endfunction

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0;
      #2 d = rd_data;
   endtask

   task automatic unlock_all();
      wr(16'h0000, 8'h0A);
      wr(16'h4000, 8'h40);
   endtask

   task automatic capture(input logic [31:0] x, input logic [31:0] y);
      @(negedge clk);
      smp_x = x; smp_y = y; smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R10 bank after reset", rom_bank, 0);
      check("R10 sample_req after reset", sample_req, 0);
      rd(WIN | 16'h0060, d);
      check("R10 locked after reset", d, 8'hFF);
      unlock_all();
      rd(WIN | 16'h0020, d); check("R10 X low reset", d, 8'hD0);
      rd(WIN | 16'h0050, d); check("R10 Y high reset", d, 8'h81);
   endtask

   task automatic t_unlock();
      logic [7:0] d;
      wr(16'h0000, 8'h00);
      rd(WIN | 16'h0060, d); check("R1 cleared by region0", d, 8'hFF);
      wr(16'h4000, 8'h40);
      wr(16'h0000, 8'h0A);
      rd(WIN | 16'h0060, d); check("R1 R2 open in either order", d, 8'h00);
      wr(16'h0000, 8'h0A);
      rd(WIN | 16'h0060, d); check("R1 rewrite keeps bit1", d, 8'h00);
      wr(16'h4000, 8'h41);
      rd(WIN | 16'h0060, d); check("R2 region2 clears bit1", d, 8'hFF);
      wr(16'h4000, 8'h40);
      rd(WIN | 16'h0060, d); check("R2 bit0 kept by region2", d, 8'h00);
      wr(16'h0000, 8'h0B);
      wr(16'h4000, 8'h40);
      rd(WIN | 16'h0060, d); check("R1 both cleared", d, 8'hFF);
      unlock_all();
   endtask

   task automatic t_bank();
      wr(16'h2000, 8'hD5);
      check("R3 bank low 7 bits", rom_bank, 7'h55);
      wr(16'h3FFF, 8'h00);
      check("R3 bank zero", rom_bank, 0);
      wr(16'h2100, 8'h7F);
      check("R3 bank max", rom_bank, 7'h7F);
   endtask

   task automatic fire_seq(input logic [7:0] a, input logic [7:0] b,
                           input int exp, input string msg);
      int c0;
      c0 = req_cnt;
      wr(WIN | 16'h0000, a);
      wr(WIN | 16'h0010, b);
      @(negedge clk); @(negedge clk);
      check(msg, req_cnt - c0, exp);
   endtask

   task automatic t_latch();
      int c0;
      fire_seq(8'h55, 8'hAA, 1, "R5 55/AA fires");
      fire_seq(8'h54, 8'hAA, 0, "R5 bad arm");
      fire_seq(8'h55, 8'hA8, 0, "R5 bad fire");
      fire_seq(8'hFF, 8'hFF, 1, "R5 masks ignore extra bits");
      c0 = req_cnt;
      wr(WIN | 16'h0000, 8'h55);
      wr(WIN | 16'h0010, 8'hAA);
      wr(WIN | 16'h0010, 8'hAA);
      @(negedge clk); @(negedge clk);
      check("R5 latch clears after fire", req_cnt - c0, 1);
      c0 = req_cnt;
      wr(WIN | 16'h0000, 8'h55);
      wr(WIN | 16'h0030, 8'h12);
      wr(WIN | 16'h0010, 8'hAA);
      @(negedge clk); @(negedge clk);
      check("R9 other slot write leaves latch", req_cnt - c0, 1);
      c0 = req_cnt;
      wr(WIN | 16'h0000, 8'h55);
      wr(16'h4000, 8'h00);
      wr(WIN | 16'h0010, 8'hAA);
      @(negedge clk); @(negedge clk);
      check("R4 locked fire ignored", req_cnt - c0, 0);
      wr(16'h4000, 8'h40);
      wr(WIN | 16'h0010, 8'hAA);
      @(negedge clk); @(negedge clk);
      check("R4 latch kept through locked write", req_cnt - c0, 1);
   endtask

   task automatic t_sensor();
      logic [7:0] d;
      logic [15:0] ex, ey;
      logic [31:0] x, y;
      x = 32'h0020_0000; y = 32'hFF60_0000;
      ex = conv(x); ey = conv(y);
      capture(x, y);
      rd(WIN | 16'h0020, d); check("R6 R7 X low", d, ex[7:0]);
      rd(WIN | 16'h0030, d); check("R6 R7 X high", d, ex[15:8]);
      rd(WIN | 16'h0040, d); check("R6 R7 Y low", d, ey[7:0]);
      rd(WIN | 16'h0050, d); check("R6 R7 Y high", d, ey[15:8]);
      x = 32'h7FFF_FFFF; y = 32'h8000_0000;
      ex = conv(x); ey = conv(y);
      capture(x, y);
      rd(WIN | 16'h0020, d); check("R6 X extreme low", d, ex[7:0]);
      rd(WIN | 16'h0030, d); check("R6 X extreme high", d, ex[15:8]);
      rd(WIN | 16'h0050, d); check("R6 Y extreme high", d, ey[15:8]);
      sens_present = 1'b0;
      rd(WIN | 16'h0020, d); check("R7 absent X low", d, 8'hFF);
      rd(WIN | 16'h0030, d); check("R7 absent X high", d, 8'h07);
      rd(WIN | 16'h0040, d); check("R7 absent Y low", d, 8'hFF);
      rd(WIN | 16'h0050, d); check("R7 absent Y high", d, 8'h07);
      sens_present = 1'b1;
   endtask

   task automatic t_same_cycle();
      logic [7:0] d;
      logic [15:0] ea, eb;
      ea = conv(32'h0140_0000); eb = conv(32'hFFE0_0000);
      capture(32'h0140_0000, 32'h0);
      rd(WIN | 16'h0020, d);
      @(negedge clk);
      smp_x = 32'hFFE0_0000; smp_valid = 1'b1;
      #2 check("R11 read during capture sees old", rd_data, ea[7:0]);
      @(negedge clk);
      smp_valid = 1'b0;
      #2 check("R11 read after capture sees new", rd_data, eb[7:0]);
      smp_x = 32'h1234_5678;
      @(negedge clk); @(negedge clk);
      #2 check("R11 held without valid", rd_data, eb[7:0]);
   endtask

   task automatic t_misc();
      logic [7:0] d;
      int c0;
      rd(WIN | 16'h0060, d); check("R8 slot 6 zero", d, 8'h00);
      ee_pins = 8'hC3;
      rd(WIN | 16'h0080, d); check("R8 pin byte", d, 8'hC3);
      rd(WIN | 16'h0070, d); check("R8 slot 7 idle", d, 8'hFF);
      rd(WIN | 16'h00F0, d); check("R8 slot F idle", d, 8'hFF);
      rd(16'h6060, d);       check("R8 outside window", d, 8'hFF);
      c0 = ee_cnt;
      wr(WIN | 16'h0080, 8'h5A);
      check("R9 pin write count", ee_cnt - c0, 1);
      check("R9 pin write data", ee_last, 8'h5A);
      wr(WIN | 16'h0090, 8'h11);
      check("R9 other slot no pin write", ee_cnt - c0, 1);
      wr(16'h4000, 8'h00);
      wr(WIN | 16'h0080, 8'h77);
      check("R4 locked pin write ignored", ee_cnt - c0, 1);
      unlock_all();
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_unlock();
            t_bank();
            t_latch();
            t_sensor();
            t_same_cycle();
            t_misc();
         end
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule